// File: doc/BRIEF.md
# Floating-Point Status and Rounding Control Register

This block keeps the accrued floating-point exception flags and the dynamic rounding mode of a processor core. Software reaches the state through three register views chosen by a 2-bit select: the flags alone, the rounding mode alone, or both packed into one word. Every view is guarded by the 2-bit floating-point context state that the status register owns. While that state is off, any access is refused. A write that is accepted raises a one-cycle request that tells the status register to mark the context dirty.

The floating-point datapath reports new exception flags on a side input, and these are merged into the stored flags. The current rounding mode and flags are also driven out so that the datapath can use them. Privilege checks, the arithmetic, and the rest of the status register are handled by other blocks.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset the flags are 0 and the rounding mode is 0, and `fp_flags`/`fp_rmode` show these values.
- R2: While `fs_state` is 2'b00, a read or write strobe on any view sets `csr_illegal` in the same cycle, `csr_rdata` is 0, and the stored state stays unchanged.
- R3: `fs_make_dirty` is 1 in exactly the cycles that carry an accepted write (`csr_wr` set and `csr_illegal` clear). This tells the status register to set its state field to 2'b11. Reads never raise it.
- R4: For select 0 (flags view), a write stores only `csr_wdata[4:0]`. A read returns the flags in bits [4:0] with zeros above.
- R5: For select 1 (rounding view), a write stores only `csr_wdata[2:0]`. A read returns the mode in bits [2:0] with zeros above.
- R6: For select 2 (combined view), a read returns the rounding mode in bits [7:5] and the flags in bits [4:0], with all higher bits 0. A write loads the mode from [7:5] and the flags from [4:0].
- R7: In every cycle with `dp_flag_vld` set, `dp_flags` is ORed into the stored flags at the next clock edge.
- R8: An accepted write to the flags or combined view in the same cycle as a datapath flag update stores the written flags and drops the update. A rounding-view write in that cycle does not block the OR.
- R9: Select 3 has no register behind it. Any strobe on it is illegal, whatever the state field, and the state is unchanged.
- R10: `csr_rdata` is 0 in any cycle without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_sel | input | 2 | View select: 0 flags, 1 rounding mode, 2 combined, 3 none |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| fs_state | input | 2 | Floating-point context state field; 2'b00 means off |
| dp_flag_vld | input | 1 | Datapath flag report valid |
| dp_flags | input | 5 | Exception flags reported by the datapath |
| csr_rdata | output | XLEN | Read data |
| csr_illegal | output | 1 | Access refused |
| fs_make_dirty | output | 1 | Request to set the state field to dirty |
| fp_rmode | output | 3 | Current rounding mode |
| fp_flags | output | 5 | Current accrued flags |

## Verification
A software write and a datapath flag report can arrive in the same cycle. The bench drives both strobes together with non-overlapping bit patterns for each of the three views. When the flags view or the combined view wins, the bench checks that the report's bits are missing from the stored flags. When the write targets only the rounding view, it checks that they are present. A reference model predicts the stored state and the port values for each cycle, and a monitor compares them. The bench reads the result back through the flags port and through the combined view in the cycles that follow.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
    localparam int FLAG_W   = 5;
    localparam int RM_W     = 3;
    localparam int STATE_W  = FLAG_W + RM_W;
    localparam int RM_LSB   = FLAG_W;
    localparam logic [1:0] FS_OFF   = 2'b00;
    localparam logic [1:0] FS_DIRTY = 2'b11;

    typedef enum logic [1:0] {
        SEL_FLAGS = 2'd0,
        SEL_RMODE = 2'd1,
        SEL_ALL   = 2'd2,
        SEL_RSVD  = 2'd3
    } view_e;

    typedef struct packed {
        logic [RM_W-1:0]   rm;
        logic [FLAG_W-1:0] fl;
    } fpstate_t;

    function automatic logic view_has_flags(view_e v);
        return (v == SEL_FLAGS) || (v == SEL_ALL);
    endfunction

    function automatic logic view_has_rm(view_e v);
        return (v == SEL_RMODE) || (v == SEL_ALL);
    endfunction
endpackage

// File: rtl/fpcsr_gate.sv
module fpcsr_gate
    import fpcsr_pkg::*;
(
    input  view_e      sel,
    input  logic       rd,
    input  logic       wr,
    input  logic [1:0] fs_state,
    output logic       illegal,
    output logic       rd_ok,
    output logic       wr_ok
);
    logic refuse;

    always_comb begin
        refuse  = (fs_state == FS_OFF) || (sel == SEL_RSVD);
        illegal = (rd || wr) && refuse;
        rd_ok   = rd && !refuse;
        wr_ok   = wr && !refuse;
    end
endmodule

// File: rtl/fpcsr_store.sv
module fpcsr_store
    import fpcsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_ok,
    input  view_e              sel,
    input  logic [STATE_W-1:0] wdata,
    input  logic               dp_vld,
    input  logic [FLAG_W-1:0]  dp_flags,
    output fpstate_t           st
);
    fpstate_t nxt;

    always_comb begin
        nxt = st;
        if (wr_ok && view_has_flags(sel))
            nxt.fl = wdata[FLAG_W-1:0];
        else if (dp_vld)
            nxt.fl = st.fl | dp_flags;

        if (wr_ok && sel == SEL_RMODE)
            nxt.rm = wdata[RM_W-1:0];
        else if (wr_ok && sel == SEL_ALL)
            nxt.rm = wdata[RM_LSB +: RM_W];
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end
endmodule

// File: rtl/fpcsr_view.sv
module fpcsr_view
    import fpcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  fpstate_t          st,
    input  view_e             sel,
    input  logic              rd_ok,
    output logic [XLEN-1:0]   rdata
);
    localparam int PAD = XLEN - STATE_W;
    logic [STATE_W-1:0] low;

    always_comb begin
        unique case (sel)
            SEL_FLAGS: low = {{RM_W{1'b0}}, st.fl};
            SEL_RMODE: low = {{FLAG_W{1'b0}}, st.rm};
            SEL_ALL:   low = st;
            default:   low = '0;
        endcase
        rdata = rd_ok ? {{PAD{1'b0}}, low} : '0;
    end
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
    import fpcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        csr_sel,
    input  logic              csr_rd,
    input  logic              csr_wr,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [1:0]        fs_state,
    input  logic              dp_flag_vld,
    input  logic [4:0]        dp_flags,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal,
    output logic              fs_make_dirty,
    output logic [2:0]        fp_rmode,
    output logic [4:0]        fp_flags
);
    view_e    sel;
    logic     rd_ok;
    logic     wr_ok;
    fpstate_t st;
    logic     unused_wdata_hi;

    assign sel             = view_e'(csr_sel);
    assign unused_wdata_hi = ^csr_wdata[XLEN-1:STATE_W];

    fpcsr_gate u_gate (
        .sel      (sel),
        .rd       (csr_rd),
        .wr       (csr_wr),
        .fs_state (fs_state),
        .illegal  (csr_illegal),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok)
    );

    fpcsr_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_ok    (wr_ok),
        .sel      (sel),
        .wdata    (csr_wdata[STATE_W-1:0]),
        .dp_vld   (dp_flag_vld),
        .dp_flags (dp_flags),
        .st       (st)
    );

    fpcsr_view #(.XLEN(XLEN)) u_view (
        .st    (st),
        .sel   (sel),
        .rd_ok (rd_ok),
        .rdata (csr_rdata)
    );

    assign fs_make_dirty = wr_ok;
    assign fp_rmode      = st.rm;
    assign fp_flags      = st.fl;
endmodule

// File: rtl/fpcsr_unit_chk.sv
module fpcsr_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      csr_sel,
    input logic            csr_rd,
    input logic            csr_wr,
    input logic [XLEN-1:0] csr_wdata,
    input logic [1:0]      fs_state,
    input logic            dp_flag_vld,
    input logic [4:0]      dp_flags,
    input logic [XLEN-1:0] csr_rdata,
    input logic            csr_illegal,
    input logic            fs_make_dirty,
    input logic [2:0]      fp_rmode,
    input logic [4:0]      fp_flags
);
    AST_OFF_REFUSED: assert property (@(posedge clk) disable iff (rst)
        ((csr_rd || csr_wr) && fs_state == 2'b00) |-> csr_illegal); // R2
    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (fs_state == 2'b00 && !dp_flag_vld) |=> ($stable(fp_flags) && $stable(fp_rmode))); // R2
    AST_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        fs_make_dirty |-> (csr_wr && !csr_illegal)); // R3
    AST_RM_LOAD: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && !csr_illegal && csr_sel == 2'd1) |=> (fp_rmode == $past(csr_wdata[2:0]))); // R5
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[XLEN-1:8] == '0); // R6
    AST_DP_ACCUM: assert property (@(posedge clk) disable iff (rst)
        (dp_flag_vld && !csr_wr) |=> ((fp_flags & $past(dp_flags)) == $past(dp_flags))); // R7
    AST_RSVD_REFUSED: assert property (@(posedge clk) disable iff (rst)
        ((csr_rd || csr_wr) && csr_sel == 2'd3) |-> csr_illegal); // R9
    AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !csr_rd |-> (csr_rdata == '0)); // R10
endmodule

bind fpcsr_unit fpcsr_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/fpcsr_unit_bench.sv
module fpcsr_unit_bench;
    localparam int XLEN = 32;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst;
    logic [1:0]      csr_sel;
    logic            csr_rd;
    logic            csr_wr;
    logic [XLEN-1:0] csr_wdata;
    logic [1:0]      fs_state;
    logic            dp_flag_vld;
    logic [4:0]      dp_flags;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_illegal;
    logic            fs_make_dirty;
    logic [2:0]      fp_rmode;
    logic [4:0]      fp_flags;

    fpcsr_unit #(.XLEN(XLEN)) u_fpcsr_unit (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [XLEN-1:0] rdata;
        logic            ill;
        logic            dirty;
        logic [4:0]      fl;
        logic [2:0]      rm;
        string           req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    logic [4:0] m_fl;
    logic [2:0] m_rm;
    bit done = 0;

    task automatic op(input logic [1:0] sel, input logic rd, input logic wr,
                      input logic [XLEN-1:0] wd, input logic [1:0] fs,
                      input logic dpv, input logic [4:0] dpf, input string req);
        exp_t e;
        logic refuse, ok_wr;
        @(negedge clk);
        csr_sel = sel; csr_rd = rd; csr_wr = wr; csr_wdata = wd;
        fs_state = fs; dp_flag_vld = dpv; dp_flags = dpf;
        refuse  = (fs == 2'b00) || (sel == 2'd3);
        ok_wr   = wr && !refuse;
        e.ill   = (rd || wr) && refuse;
        e.dirty = ok_wr;
        e.fl    = m_fl;
        e.rm    = m_rm;
        e.req   = req;
        e.rdata = '0;
        if (rd && !refuse) begin
            case (sel)
                2'd0: e.rdata = {27'd0, m_fl};
                2'd1: e.rdata = {29'd0, m_rm};
                default: e.rdata = {24'd0, m_rm, m_fl};
            endcase
        end
        exp_q.push_back(e);
        if (ok_wr && (sel == 2'd0 || sel == 2'd2)) m_fl = wd[4:0];
        else if (dpv) m_fl = m_fl | dpf;
        if (ok_wr && sel == 2'd1) m_rm = wd[2:0];
        else if (ok_wr && sel == 2'd2) m_rm = wd[7:5];
    endtask

    task automatic cmp(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.req, "rdata",   csr_rdata, e.rdata);
                cmp(e.req, "illegal", {31'd0, csr_illegal}, {31'd0, e.ill});
                cmp(e.req, "dirty",   {31'd0, fs_make_dirty}, {31'd0, e.dirty});
                cmp(e.req, "flags",   {27'd0, fp_flags}, {27'd0, e.fl});
                cmp(e.req, "rmode",   {29'd0, fp_rmode}, {29'd0, e.rm});
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        rst = 1'b1; csr_sel = 0; csr_rd = 0; csr_wr = 0; csr_wdata = 0;
        fs_state = 2'b01; dp_flag_vld = 0; dp_flags = 0;
        m_fl = 0; m_rm = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state, seen on the outputs and through the combined view
        op(2'd2, 1, 0, 0, 2'b01, 0, 0, "R1");
        // R4 flags view keeps only the low five bits; R3 dirty on accepted write
        op(2'd0, 0, 1, 32'hFFFF_FFEA, 2'b01, 0, 0, "R4");
        op(2'd0, 1, 0, 0, 2'b10, 0, 0, "R4");
        // R5 rounding view keeps three bits
        op(2'd1, 0, 1, 32'hFFFF_FFFE, 2'b11, 0, 0, "R5");
        op(2'd1, 1, 0, 0, 2'b11, 0, 0, "R5");
        // R6 combined write and read
        op(2'd2, 0, 1, 32'h1234_56A5, 2'b01, 0, 0, "R6");
        op(2'd2, 1, 0, 0, 2'b01, 0, 0, "R6");
        op(2'd0, 1, 0, 0, 2'b01, 0, 0, "R6");
        op(2'd1, 1, 0, 0, 2'b01, 0, 0, "R6");
        // R2 off: read and write refused, state unchanged
        op(2'd2, 1, 0, 0, 2'b00, 0, 0, "R2");
        op(2'd2, 0, 1, 32'h0000_00FF, 2'b00, 0, 0, "R2");
        op(2'd1, 0, 1, 32'h0000_0003, 2'b00, 0, 0, "R2");
        op(2'd2, 1, 0, 0, 2'b01, 0, 0, "R2");
        // R9 reserved select
        op(2'd3, 1, 1, 32'h0000_00FF, 2'b11, 0, 0, "R9");
        op(2'd2, 1, 0, 0, 2'b11, 0, 0, "R9");
        // R10 no strobe gives zero read data
        op(2'd2, 0, 0, 0, 2'b11, 0, 0, "R10");
        // R7 datapath accumulation over two cycles
        op(2'd0, 0, 1, 32'h0, 2'b11, 0, 0, "R7");
        op(2'd0, 0, 0, 0, 2'b11, 1, 5'b00010, "R7");
        op(2'd0, 0, 0, 0, 2'b11, 1, 5'b10000, "R7");
        op(2'd0, 1, 0, 0, 2'b11, 0, 0, "R7");
        // R8 collisions
        op(2'd0, 0, 1, 32'h0000_0001, 2'b01, 1, 5'b01000, "R8");
        op(2'd0, 1, 0, 0, 2'b01, 0, 0, "R8");
        op(2'd2, 0, 1, 32'h0000_0044, 2'b01, 1, 5'b00011, "R8");
        op(2'd2, 1, 0, 0, 2'b01, 0, 0, "R8");
        op(2'd1, 0, 1, 32'h0000_0006, 2'b01, 1, 5'b10001, "R8");
        op(2'd2, 1, 0, 0, 2'b01, 0, 0, "R8");
        // R2 datapath update still merges while software access is off
        op(2'd2, 1, 0, 0, 2'b00, 1, 5'b01000, "R2");
        op(2'd2, 1, 0, 0, 2'b01, 0, 0, "R2");
        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_fl = 0; m_rm = 0;
        op(2'd2, 1, 0, 0, 2'b01, 0, 0, "R1");
        op(2'd0, 0, 0, 0, 2'b01, 0, 0, "R1");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule